// File: doc/BRIEF.md
# CSR Instruction Execute Unit

This unit executes the six control-and-status-register instructions of a 32-bit core against a small local CSR file. It also turns the environment-call and breakpoint encodings into trap outputs. Each cycle it accepts one system-opcode instruction word and the value of the rs1 source register. From these it finds the operation in funct3 and the source operand, which is either the register value or a 5-bit immediate taken from the rs1 field. It then decides whether the CSR is written and whether rd receives the old CSR value.

The response is registered and arrives one cycle after issue. The CSR update lands on the same clock edge that registers the writeback. As a result, rd data never appears unless the CSR write it belongs to has also been done. The CSR file holds a parameterised run of read-write registers, which reset to zero, and a run of read-only registers whose values are fixed constants. Addresses in the read-only space (bits 11:10 equal to 11) refuse any write. Any address outside the implemented set refuses every access.

Top module: `csr_exec_unit`

## Requirements
- R1: funct3 001 (register swap) and 101 (immediate swap) write the source operand into the addressed CSR. When rd is not 0, the CSR's previous value is returned on rd_data with rd_we high.
- R2: funct3 010 and 110 write old|src into the CSR. funct3 011 and 111 write old&~src. In both cases rd receives the old value.
- R3: For funct3 101, 110 and 111 the source is the 5-bit rs1 field (instr[19:15]) zero-extended to 32 bits. rs1_data is ignored.
- R4: The set and clear forms perform no CSR write when the rs1 field is 0, whether it is used as a register index or as an immediate. When rd is not 0 they still return the old value.
- R5: When the rd field (instr[11:7]) is 0, rd_we stays low. The swap forms still write the CSR.
- R6: resp_valid follows issue_valid by exactly one cycle. The new CSR value is what the next back-to-back instruction reads.
- R7: The word 0x00000073 gives trap_valid with trap_cause 11 and no rd write.
- R8: The word 0x00100073 gives trap_valid with trap_cause 3 and no rd write.
- R9: An access to an address outside the implemented CSRs (read-write at 0x340 and 0x341, read-only at 0xF11 and 0xF12) gives trap_cause 2 and changes no CSR.
- R10: Any write attempt to a read-only address gives trap_cause 2. A set or clear with a zero source reads it and returns its constant value (0x5A000001 plus its index).
- R11: Other words, meaning a wrong opcode (instr[6:0] not 1110011), funct3 100, or funct3 000 that is not exactly one of the two trap words, give trap_cause 2 with no effect.
- R12: After reset the read-write CSRs are 0 and resp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_data | input | 32 | Value of the register selected by the rs1 field |
| resp_valid | output | 1 | Response for the instruction issued last cycle |
| rd_we | output | 1 | Write rd_data to register rd_idx |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Old CSR value |
| trap_valid | output | 1 | Instruction traps instead of executing |
| trap_cause | output | 4 | 2 illegal, 3 breakpoint, 11 environment call |

## Verification
Random streams mix all six funct3 variants over read-write, read-only and unimplemented addresses. The rs1 and rd fields are often zero, and rs1_data values are random. This separates register-sourced operands from immediate-sourced ones and write-suppressing zero sources from true writes. Back-to-back issues against the same CSR show whether each update is visible to the next reader. Directed words cover the two trap encodings, near-miss encodings, funct3 100 and a wrong opcode. A read-back after each refused access confirms the CSR contents did not move.

// File: rtl/csr_exec_pkg.sv
package csr_exec_pkg;
   localparam logic [6:0] SYS_OPCODE   = 7'b1110011;
   localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
   localparam logic [3:0] CAUSE_BREAK   = 4'd3;
   localparam logic [3:0] CAUSE_ENVCALL = 4'd11;

   typedef enum logic [1:0] {
      UPD_SWAP  = 2'd0,
      UPD_SET   = 2'd1,
      UPD_CLEAR = 2'd2
   } upd_kind_e;

   typedef struct packed {
      logic        is_csr;
      logic        is_envcall;
      logic        is_break;
      logic        is_bad;
      logic [11:0] addr;
      logic [4:0]  rd;
      logic [4:0]  src_idx;
      logic        use_imm;
      upd_kind_e   kind;
      logic        wr_req;
   } csr_dec_t;
endpackage

// File: rtl/csr_decode.sv
module csr_decode
   import csr_exec_pkg::*;
(
   input  logic [31:0] instr,
   output csr_dec_t    dec
);
   logic [2:0] f3;
   logic       sys;

   assign f3  = instr[14:12];
   assign sys = (instr[6:0] == SYS_OPCODE);

   always_comb begin
      dec            = '0;
      dec.addr       = instr[31:20];
      dec.rd         = instr[11:7];
      dec.src_idx    = instr[19:15];
      dec.use_imm    = f3[2];
      dec.is_envcall = (instr == 32'h0000_0073);
      dec.is_break   = (instr == 32'h0010_0073);
      unique case (f3[1:0])
         2'b01:   dec.kind = UPD_SWAP;
         2'b10:   dec.kind = UPD_SET;
         default: dec.kind = UPD_CLEAR;
      endcase
      dec.is_csr = sys && (f3[1:0] != 2'b00);
      // swaps always write; set/clear only with a non-zero source field
      dec.wr_req = dec.is_csr && ((dec.kind == UPD_SWAP) || (dec.src_idx != 5'd0));
      dec.is_bad = !dec.is_csr && !dec.is_envcall && !dec.is_break;
   end
endmodule

// File: rtl/csr_update.sv
module csr_update
   import csr_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] src_val,
   input  upd_kind_e       kind,
   output logic [XLEN-1:0] new_val
);
   always_comb begin
      unique case (kind)
         UPD_SWAP:  new_val = src_val;
         UPD_SET:   new_val = old_val | src_val;
         default:   new_val = old_val & ~src_val;
      endcase
   end
endmodule

// File: rtl/csr_file.sv
module csr_file #(
   parameter int          XLEN    = 32,
   parameter int          NUM_RW  = 2,
   parameter logic [11:0] RW_BASE = 12'h340,
   parameter int          NUM_RO  = 2,
   parameter logic [11:0] RO_BASE = 12'hF11,
   parameter logic [31:0] RO_SEED = 32'h5A00_0001
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [11:0]     addr,
   input  logic            wr_en,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] rdata,
   output logic            hit,
   output logic            read_only
);
   logic [NUM_RW-1:0]     hit_rw;
   logic [NUM_RO-1:0]     hit_ro;
   logic [XLEN-1:0]       rw_q [NUM_RW];
   logic [XLEN-1:0]       rw_rd [NUM_RW];
   logic [XLEN-1:0]       ro_rd [NUM_RO];

   for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
      assign hit_rw[i] = (addr == RW_BASE + 12'(i));
      assign rw_rd[i]  = hit_rw[i] ? rw_q[i] : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                rw_q[i] <= '0;
         else if (wr_en && hit_rw[i]) rw_q[i] <= wr_data;
      end
      // R9
      rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(wr_en && hit_rw[i]) |-> $stable(rw_q[i]));
   end

   for (genvar j = 0; j < NUM_RO; j++) begin : g_ro
      assign hit_ro[j] = (addr == RO_BASE + 12'(j));
      assign ro_rd[j]  = hit_ro[j] ? XLEN'(RO_SEED + 32'(j)) : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_RW; i++) rdata |= rw_rd[i];
      for (int j = 0; j < NUM_RO; j++) rdata |= ro_rd[j];
   end

   assign hit       = (|hit_rw) || (|hit_ro);
   assign read_only = |hit_ro;

   // R10
   ro_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (|hit_rw));
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
   import csr_exec_pkg::*;
#(
   parameter int          XLEN    = 32,
   parameter int          NUM_RW  = 2,
   parameter logic [11:0] RW_BASE = 12'h340,
   parameter int          NUM_RO  = 2,
   parameter logic [11:0] RO_BASE = 12'hF11,
   parameter logic [31:0] RO_SEED = 32'h5A00_0001
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        issue_valid,
   input  logic [31:0] instr,
   input  logic [31:0] rs1_data,
   output logic        resp_valid,
   output logic        rd_we,
   output logic [4:0]  rd_idx,
   output logic [31:0] rd_data,
   output logic        trap_valid,
   output logic [3:0]  trap_cause
);
   localparam int IMM_W = 5;

   if (XLEN != 32) begin : g_bad_xlen
      $error("csr_exec_unit: XLEN must be 32");
   end
   if (NUM_RW < 1 || NUM_RO < 1) begin : g_bad_count
      $error("csr_exec_unit: at least one CSR of each kind");
   end
   if (RO_BASE[11:10] != 2'b11 || RW_BASE[11:10] == 2'b11) begin : g_bad_map
      $error("csr_exec_unit: read-only base must sit in space 11, read-write outside it");
   end

   csr_dec_t        dec;
   logic [XLEN-1:0] old_val, src_val, new_val;
   logic            hit, read_only, legal, file_we, do_trap;
   logic [3:0]      cause_c;

   csr_decode u_dec (.instr(instr), .dec(dec));

   assign src_val = dec.use_imm ? {{(XLEN-IMM_W){1'b0}}, dec.src_idx} : rs1_data;

   csr_update #(.XLEN(XLEN)) u_upd (
      .old_val(old_val), .src_val(src_val), .kind(dec.kind), .new_val(new_val));

   assign legal   = dec.is_csr && hit && !(read_only && dec.wr_req);
   assign file_we = issue_valid && legal && dec.wr_req;

   csr_file #(
      .XLEN(XLEN), .NUM_RW(NUM_RW), .RW_BASE(RW_BASE),
      .NUM_RO(NUM_RO), .RO_BASE(RO_BASE), .RO_SEED(RO_SEED)
   ) u_file (
      .clk(clk), .rst_n(rst_n), .addr(dec.addr), .wr_en(file_we),
      .wr_data(new_val), .rdata(old_val), .hit(hit), .read_only(read_only));

   always_comb begin
      do_trap = 1'b1;
      cause_c = CAUSE_ILLEGAL;
      if (dec.is_envcall)    cause_c = CAUSE_ENVCALL;
      else if (dec.is_break) cause_c = CAUSE_BREAK;
      else if (legal)        do_trap = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         rd_we      <= 1'b0;
         rd_idx     <= '0;
         rd_data    <= '0;
         trap_valid <= 1'b0;
         trap_cause <= '0;
      end else begin
         resp_valid <= issue_valid;
         rd_we      <= issue_valid && legal && (dec.rd != 5'd0);
         rd_idx     <= dec.rd;
         rd_data    <= old_val;
         trap_valid <= issue_valid && do_trap;
         trap_cause <= do_trap ? cause_c : 4'd0;
      end
   end

   // R6
   resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(issue_valid));
   // R7
   trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_we && trap_valid));
   // R5
   rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (rd_idx != 5'd0) && resp_valid);
   // R4
   zero_src_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && instr[13] && instr[19:15] == 5'd0) |-> !file_we);
endmodule

// File: tb/csr_exec_unit_bench.sv
module csr_exec_unit_bench;
   localparam logic [11:0] RW0   = 12'h340;
   localparam logic [11:0] RO0   = 12'hF11;
   localparam logic [31:0] SEED  = 32'h5A00_0001;
   localparam logic [11:0] UNIMP = 12'h300;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs1_data = '0;
   logic        resp_valid, rd_we, trap_valid;
   logic [4:0]  rd_idx;
   logic [31:0] rd_data;
   logic [3:0]  trap_cause;

   int checks = 0;
   int fails  = 0;
   logic [31:0] m_rw [2];

   always #10 clk = ~clk;

   csr_exec_unit u_csr_exec_unit (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
      .rs1_data(rs1_data), .resp_valid(resp_valid), .rd_we(rd_we),
      .rd_idx(rd_idx), .rd_data(rd_data), .trap_valid(trap_valid),
      .trap_cause(trap_cause));

   function automatic logic [31:0] mk(logic [11:0] a, logic [4:0] s,
                                      logic [2:0] f3, logic [4:0] rd);
      return {a, s, f3, rd, 7'b1110011};
   endfunction

   task automatic run(input logic [31:0] ins, input logic [31:0] r1, input string tag);
      logic [2:0]  f3 = ins[14:12];
      logic [11:0] a  = ins[31:20];
      logic [4:0]  s  = ins[19:15];
      logic [4:0]  rd = ins[11:7];
      logic        e_trap = 1'b0, e_we = 1'b0, wr = 1'b0, is_rw, is_ro;
      logic [3:0]  e_cause = 4'd0;
      logic [31:0] old = '0, src, nv;
      int          idx = 0;
      is_rw = (a == RW0) || (a == RW0 + 12'd1);
      is_ro = (a == RO0) || (a == RO0 + 12'd1);
      if (is_rw) begin idx = int'(a - RW0); old = m_rw[idx]; end
      if (is_ro) old = SEED + 32'(a - RO0);
      src = f3[2] ? {27'd0, s} : r1;
      wr  = (f3[1:0] == 2'b01) || (s != 5'd0);
      nv  = (f3[1:0] == 2'b01) ? src : (f3[1:0] == 2'b10) ? (old | src) : (old & ~src);
      if (ins == 32'h0000_0073) begin e_trap = 1; e_cause = 11; end
      else if (ins == 32'h0010_0073) begin e_trap = 1; e_cause = 3; end
      else if (ins[6:0] != 7'b1110011 || f3[1:0] == 2'b00) begin e_trap = 1; e_cause = 2; end
      else if (!(is_rw || is_ro) || (is_ro && wr)) begin e_trap = 1; e_cause = 2; end
      else e_we = (rd != 5'd0);
      issue_valid = 1'b1; instr = ins; rs1_data = r1;
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b1 || rd_we !== e_we || trap_valid !== e_trap ||
          trap_cause !== e_cause || (e_we && (rd_idx !== rd || rd_data !== old))) begin
         fails++;
         $display("FAIL %s ins=%h: got v=%b we=%b idx=%0d data=%h trap=%b cause=%0d exp we=%b idx=%0d data=%h trap=%b cause=%0d",
                  tag, ins, resp_valid, rd_we, rd_idx, rd_data, trap_valid, trap_cause,
                  e_we, rd, old, e_trap, e_cause);
      end
      if (!e_trap && wr && is_rw) m_rw[idx] = nv;
   endtask

   task automatic idle();
      issue_valid = 1'b0;
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R6 resp_valid without issue: got %b exp 0", resp_valid);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      m_rw[0] = '0; m_rw[1] = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0 || rd_we !== 1'b0 || trap_valid !== 1'b0) begin
         fails++;
         $display("FAIL R12 reset outputs: got %b%b%b exp 000", resp_valid, rd_we, trap_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R12: both read-write CSRs read as zero after reset
      run(mk(RW0, 5'd0, 3'b010, 5'd1), 32'hFFFF_FFFF, "R12");
      run(mk(RW0 + 12'd1, 5'd0, 3'b011, 5'd2), 32'hFFFF_FFFF, "R12");
      // R1 swap register, then back-to-back read (R6)
      run(mk(RW0, 5'd7, 3'b001, 5'd3), 32'hDEAD_BEEF, "R1");
      run(mk(RW0, 5'd9, 3'b001, 5'd4), 32'h1234_5678, "R6");
      // R5 rd zero swap still writes
      run(mk(RW0, 5'd9, 3'b001, 5'd0), 32'hA5A5_0F0F, "R5");
      run(mk(RW0, 5'd0, 3'b010, 5'd5), 32'h0, "R5");
      // R2 set and clear from register
      run(mk(RW0, 5'd1, 3'b010, 5'd6), 32'h0000_F0F0, "R2");
      run(mk(RW0, 5'd1, 3'b011, 5'd6), 32'hA000_000F, "R2");
      // R3 immediate forms ignore rs1_data
      run(mk(RW0 + 12'd1, 5'd31, 3'b101, 5'd7), 32'hFFFF_FFFF, "R3");
      run(mk(RW0 + 12'd1, 5'd6, 3'b111, 5'd7), 32'hFFFF_FFFF, "R3");
      run(mk(RW0 + 12'd1, 5'd20, 3'b110, 5'd7), 32'h0, "R3");
      // R4 zero source: no write for set/clear, value still returned
      run(mk(RW0, 5'd0, 3'b011, 5'd8), 32'hFFFF_FFFF, "R4");
      run(mk(RW0, 5'd0, 3'b111, 5'd8), 32'h0, "R4");
      run(mk(RW0, 5'd0, 3'b110, 5'd8), 32'h0, "R4");
      // R10 read-only space
      run(mk(RO0, 5'd0, 3'b010, 5'd9), 32'hFFFF_FFFF, "R10");
      run(mk(RO0 + 12'd1, 5'd0, 3'b111, 5'd9), 32'h0, "R10");
      run(mk(RO0, 5'd3, 3'b001, 5'd9), 32'h0, "R10");
      run(mk(RO0, 5'd4, 3'b110, 5'd0), 32'h0, "R10");
      run(mk(RO0, 5'd0, 3'b010, 5'd9), 32'h0, "R10");
      // R9 unimplemented address, then confirm neighbour unchanged
      run(mk(UNIMP, 5'd5, 3'b001, 5'd10), 32'hFFFF_FFFF, "R9");
      run(mk(RW0 + 12'd2, 5'd5, 3'b101, 5'd10), 32'h0, "R9");
      run(mk(RW0 + 12'd1, 5'd0, 3'b010, 5'd10), 32'h0, "R9");
      // R7 R8 R11 trap words
      run(32'h0000_0073, 32'h0, "R7");
      run(32'h0010_0073, 32'h0, "R8");
      run(32'h0000_00F3, 32'h0, "R11");
      run(32'h0020_0073, 32'h0, "R11");
      run(mk(RW0, 5'd1, 3'b100, 5'd1), 32'h1, "R11");
      run({RW0, 5'd1, 3'b001, 5'd1, 7'b0110011}, 32'h1, "R11");
      run(mk(RW0, 5'd0, 3'b010, 5'd1), 32'h0, "R11");
      idle();
      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [11:0] a;
         logic [2:0]  f3;
         logic [4:0]  s, rd;
         int          pick = int'($urandom_range(0, 5));
         a  = (pick < 2) ? RW0 + 12'(pick) : (pick < 4) ? RO0 + 12'(pick - 2) :
              (pick == 4) ? UNIMP : RW0 + 12'd2;
         f3 = 3'($urandom_range(0, 5));
         f3 = (f3 < 3) ? f3 + 3'd1 : f3 + 3'd2;
         s  = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
         rd = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
         run(mk(a, s, f3, rd), $urandom, "R1/R2 random");
         if ($urandom_range(0, 15) == 0) idle();
      end
      idle();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule